// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block sits on the host side of a byte-wide flash device and writes one byte into it with a bounded pulse-and-check loop. A one-cycle start request carries a target address and data byte. The sequencer then raises its high-voltage enable and performs one attempt. An attempt is a program-setup write, a data write and a programming pulse of fixed length. After the pulse it writes the verify command, waits a few clocks and reads the byte back. If the read data equals the target, the loop ends with success. Otherwise another attempt follows, up to a fixed number of attempts. After that the byte is declared failed.

When the loop ends for either reason, the sequencer writes the read command to the device and drops the high-voltage enable. It then shows a one-cycle done strobe, with the fail flag beside it. Each request stands alone, so bytes can be written at any addresses and in any order. The number of pulses issued for the current byte appears on a count output.

Top module: `flash_byte_prog`

## Requirements
- R1: After reset, busy, done, fail, hv_en, fl_we and fl_re are low and attempts is zero.
- R2: start is only taken while the sequencer is idle. A start pulse during a running sequence does not change its timing, its bus writes or the address it drives.
- R3: The first cycle after an accepted start opens attempt one. Each attempt writes 8'h40 to the target address, writes the target data there in the next cycle, and then leaves the bus quiet for exactly PULSE_CYCLES = CLK_HZ/1000*PULSE_MS cycles.
- R4: After each pulse, 8'hC0 is written, the bus stays quiet for exactly VFY_WAIT cycles, and then one read strobe is issued at the target address. Read data is sampled in the same cycle as the read strobe. A full attempt therefore takes PULSE_CYCLES+VFY_WAIT+4 cycles.
- R5: A verify read that equals the target data ends the loop with success, and fail stays low at done.
- R6: A verify read that differs from the target starts another attempt in the next cycle, as long as fewer than MAX_PULSES pulses have been issued.
- R7: If the read after pulse number MAX_PULSES still differs, the loop ends and fail is high together with done.
- R8: When the loop ends, the cycle after the last read writes 8'h00 to the target address. done is high for exactly one cycle after that, with busy and hv_en already low.
- R9: hv_en is high from the first setup write through the final 8'h00 write, and every bus strobe happens while hv_en is high.
- R10: attempts is cleared on an accepted start, goes up by one with each data write, and at done equals the number of pulses issued.
- R11: Successive requests may target any addresses in any order, and each starts its attempt count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to program a byte |
| addr_in | input | ADDR_W | Target address, taken with start |
| data_in | input | 8 | Target data, taken with start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Byte did not verify, valid with done |
| hv_en | output | 1 | High-voltage supply enable |
| attempts | output | clog2(MAX_PULSES+1) | Pulses issued for the current byte |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | 8 | Flash bus write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, sampled while fl_re is high |

## Verification
Each attempt has a fixed length, so a wrong timer load or an extra state shifts the verify write or the read strobe by whole cycles. That error already shows in the first attempt, within about PULSE_CYCLES+VFY_WAIT cycles of start. A wrong attempt count or limit compare shows up later, either as a wrong number of bus events before done or as a fail flag and attempts value that do not match how many pulses the device model needed. A latched address or data value that changes is seen at the next bus strobe after the spurious start.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_SETUP  = 8'h40;
    localparam logic [BYTE_W-1:0] OP_VERIFY = 8'hC0;
    localparam logic [BYTE_W-1:0] OP_READ   = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PROG,
        ST_PULSE,
        ST_VCMD,
        ST_VWAIT,
        ST_VREAD,
        ST_RDCMD,
        ST_REPORT
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [BYTE_W-1:0] wdata;
    } bus_op_t;

    function automatic bus_op_t bus_op_for(seq_state_e s, logic [BYTE_W-1:0] tgt);
        bus_op_t op;
        op = '{we: 1'b0, re: 1'b0, wdata: '0};
        case (s)
            ST_SETUP: begin op.we = 1'b1; op.wdata = OP_SETUP;  end
            ST_PROG:  begin op.we = 1'b1; op.wdata = tgt;       end
            ST_VCMD:  begin op.we = 1'b1; op.wdata = OP_VERIFY; end
            ST_RDCMD: begin op.we = 1'b1; op.wdata = OP_READ;   end
            ST_VREAD: op.re = 1'b1;
            default:  ;
        endcase
        return op;
    endfunction

    function automatic logic seq_active(seq_state_e s);
        return (s != ST_IDLE) && (s != ST_REPORT);
    endfunction

endpackage

// File: rtl/fbp_timer.sv
module fbp_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/fbp_attempts.sv
module fbp_attempts #(
    parameter int LIMIT = 25,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          bump,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (bump && count != CW'(LIMIT))
            count <= count + 1'b1;
    end

    assign at_limit = (count == CW'(LIMIT));
endmodule

// File: rtl/fbp_bus_drive.sv
module fbp_bus_drive #(
    parameter int ADDR_W = 17
) (
    input  fbp_pkg::seq_state_e       state,
    input  logic [ADDR_W-1:0]         tgt_addr,
    input  logic [fbp_pkg::BYTE_W-1:0] tgt_data,
    output logic [ADDR_W-1:0]         fl_addr,
    output logic [fbp_pkg::BYTE_W-1:0] fl_wdata,
    output logic                      fl_we,
    output logic                      fl_re
);
    fbp_pkg::bus_op_t op;

    always_comb begin
        op       = fbp_pkg::bus_op_for(state, tgt_data);
        fl_we    = op.we;
        fl_re    = op.re;
        fl_wdata = op.wdata;
        fl_addr  = tgt_addr;
    end
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
    import fbp_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_MS   = 10,
    parameter int MAX_PULSES = 25,
    parameter int VFY_WAIT   = 3,
    parameter int ADDR_W     = 17
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [ADDR_W-1:0]                 addr_in,
    input  logic [7:0]                        data_in,
    output logic                              busy,
    output logic                              done,
    output logic                              fail,
    output logic                              hv_en,
    output logic [$clog2(MAX_PULSES+1)-1:0]   attempts,
    output logic [ADDR_W-1:0]                 fl_addr,
    output logic [7:0]                        fl_wdata,
    output logic                              fl_we,
    output logic                              fl_re,
    input  logic [7:0]                        fl_rdata
);
    localparam int PULSE_CYCLES = CLK_HZ / 1000 * PULSE_MS;
    localparam int LONGEST      = (PULSE_CYCLES > VFY_WAIT) ? PULSE_CYCLES : VFY_WAIT;
    localparam int TMR_W        = $clog2(LONGEST + 1);
    localparam int CNT_W        = $clog2(MAX_PULSES + 1);

    seq_state_e        state, state_nx;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BYTE_W-1:0] tgt_data;
    logic              fail_q;
    logic              accept;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              at_limit;
    logic              verified;

    assign accept   = (state == ST_IDLE) && start;
    assign verified = (fl_rdata == tgt_data);

    fbp_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fbp_attempts #(.LIMIT(MAX_PULSES), .CW(CNT_W)) u_attempts (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .bump     (state == ST_PROG),
        .count    (attempts),
        .at_limit (at_limit)
    );

    fbp_bus_drive #(.ADDR_W(ADDR_W)) u_bus (
        .state    (state),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_we    (fl_we),
        .fl_re    (fl_re)
    );

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE:   if (start) state_nx = ST_SETUP;
            ST_SETUP:  state_nx = ST_PROG;
            ST_PROG: begin
                state_nx = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(PULSE_CYCLES - 1);
            end
            ST_PULSE:  if (tmr_expired) state_nx = ST_VCMD;
            ST_VCMD: begin
                state_nx = ST_VWAIT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(VFY_WAIT - 1);
            end
            ST_VWAIT:  if (tmr_expired) state_nx = ST_VREAD;
            ST_VREAD:  state_nx = (verified || at_limit) ? ST_RDCMD : ST_SETUP;
            ST_RDCMD:  state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            fail_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                tgt_addr <= addr_in;
                tgt_data <= data_in;
                fail_q   <= 1'b0;
            end else if (state == ST_VREAD && !verified && at_limit) begin
                fail_q <= 1'b1;
            end
        end
    end

    assign busy  = seq_active(state);
    assign hv_en = seq_active(state);
    assign done  = (state == ST_REPORT);
    assign fail  = (state == ST_REPORT) && fail_q;
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
    parameter int MAX_PULSES = 25,
    parameter int ADDR_W     = 17
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            start,
    input logic                            busy,
    input logic                            done,
    input logic                            fail,
    input logic                            hv_en,
    input logic [$clog2(MAX_PULSES+1)-1:0] attempts,
    input logic [ADDR_W-1:0]               fl_addr,
    input logic [7:0]                      fl_wdata,
    input logic                            fl_we,
    input logic                            fl_re
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    // R9
    hv_on_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_we || fl_re) |-> hv_en);

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    // R4
    read_gap_chk: assert property (@(posedge clk) disable iff (rst)
        fl_re |-> !$past(fl_we));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !hv_en && !fl_we && !fl_re));

    // R8
    done_after_read_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(fl_we) && $past(fl_wdata) == 8'h00));

    // R7
    fail_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> (done && attempts == CW'(MAX_PULSES)));

    // R10
    attempts_bound_chk: assert property (@(posedge clk) disable iff (rst)
        attempts <= CW'(MAX_PULSES));

    // R2
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(fl_addr));
endmodule

bind flash_byte_prog fbp_checker #(
    .MAX_PULSES (MAX_PULSES),
    .ADDR_W     (ADDR_W)
) u_fbp_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .hv_en    (hv_en),
    .attempts (attempts),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we    (fl_we),
    .fl_re    (fl_re)
);

// File: tb/flash_byte_prog_test.sv
module flash_byte_prog_test;
    localparam int CLK_HZ = 1000;
    localparam int PMS    = 10;
    localparam int MAXP   = 6;
    localparam int VW     = 3;
    localparam int AW     = 8;
    localparam int P      = CLK_HZ / 1000 * PMS;
    localparam int T      = P + VW + 4;
    localparam int CW     = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    data_in = '0;
    logic          busy, done, fail, hv_en, fl_we, fl_re;
    logic [CW-1:0] attempts;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata, fl_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    int cyc = 0;

    int            ev_t [64];
    bit            ev_rd[64];
    logic [7:0]    ev_d [64];
    logic [AW-1:0] ev_a [64];
    int            ev_n = 0;
    int            done_n = 0, done_t = 0, att_seen = 0, hv_bad = 0, prog_cnt = 0, t0 = 0;
    bit            fail_seen = 1'b0, last_setup = 1'b0;
    logic [7:0]    tgt = '0;
    int            need = 1;

    flash_byte_prog #(
        .CLK_HZ(CLK_HZ), .PULSE_MS(PMS), .MAX_PULSES(MAXP), .VFY_WAIT(VW), .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .addr_in(addr_in), .data_in(data_in),
        .busy(busy), .done(done), .fail(fail), .hv_en(hv_en), .attempts(attempts),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // device model: the byte reads back correctly once enough pulses were given
    assign fl_rdata = (prog_cnt >= need) ? tgt : ~tgt;

    always @(negedge clk) begin
        if (!rst) begin
            if (fl_we || fl_re) begin
                if (ev_n < 64) begin
                    ev_t[ev_n]  = cyc - t0 - 1;
                    ev_rd[ev_n] = fl_re;
                    ev_d[ev_n]  = fl_wdata;
                    ev_a[ev_n]  = fl_addr;
                end
                ev_n++;
                if (!hv_en) hv_bad++;
            end
            if (fl_we) begin
                if (last_setup) prog_cnt++;
                last_setup = (fl_wdata == 8'h40);
            end
            if (done) begin
                done_n++;
                done_t    = cyc - t0 - 1;
                fail_seen = fail;
                att_seen  = int'(attempts);
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        finished = 1'b1;
        $finish;
    endtask

    task automatic run_op(logic [AW-1:0] a, logic [7:0] d, int nd, bit inject);
        int n, guard, bad3, bad4, bada, badfin;
        bit pass;
        tgt = d; need = nd; ev_n = 0; done_n = 0; prog_cnt = 0;
        last_setup = 1'b0; hv_bad = 0;
        @(negedge clk);
        addr_in = a; data_in = d; start = 1'b1; t0 = cyc;
        @(negedge clk);
        start = 1'b0; addr_in = ~a; data_in = ~d;
        if (inject) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check("R8", "done timeout", int'(guard >= 2000), 0);
        @(negedge clk);
        check("R8", "done width", done_n, 1);
        check("R8", "busy after done", int'(busy), 0);
        check("R9", "hv after done", int'(hv_en), 0);

        pass = (nd <= MAXP);
        n = pass ? nd : MAXP;
        check("R6", "bus event count", ev_n, 4 * n + 1);
        bad3 = 0; bad4 = 0; bada = 0; badfin = 0;
        if (ev_n == 4 * n + 1) begin
            for (int k = 0; k < 4 * n; k++) begin
                int base = (k / 4) * T;
                case (k % 4)
                    0: if (ev_rd[k] || ev_d[k] != 8'h40 || ev_t[k] != base) bad3++;
                    1: if (ev_rd[k] || ev_d[k] != d || ev_t[k] != base + 1) bad3++;
                    2: if (ev_rd[k] || ev_d[k] != 8'hC0 || ev_t[k] != base + 2 + P) bad3++;
                    default: if (!ev_rd[k] || ev_t[k] != base + 3 + P + VW) bad4++;
                endcase
            end
            for (int k = 0; k <= 4 * n; k++)
                if (ev_a[k] != a) bada++;
            if (ev_rd[4*n] || ev_d[4*n] != 8'h00 || ev_t[4*n] != n * T) badfin++;
        end
        check("R3", "setup/data/pulse event errors", bad3, 0);
        check("R4", "verify read event errors", bad4, 0);
        check("R2", "address errors", bada, 0);
        check("R8", "final read-command errors", badfin, 0);
        check("R8", "done cycle", done_t, n * T + 1);
        check(pass ? "R5" : "R7", "fail flag", int'(fail_seen), int'(!pass));
        check("R10", "attempts at done", att_seen, n);
        check("R9", "strobes without hv", hv_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "fail", int'(fail), 0);
        check("R1", "hv_en", int'(hv_en), 0);
        check("R1", "strobes", int'(fl_we || fl_re), 0);
        check("R1", "attempts", int'(attempts), 0);
        // R11: addresses visited in a scrambled order, count restarts each byte
        for (int v = 0; v < 3; v++)
            for (int nd = 1; nd <= MAXP + 1; nd++)
                run_op(AW'((nd * 73 + v * 151 + 17) % 256), 8'((nd * 29 + v * 90 + 3) % 256),
                       nd, ((nd + v) % 2) == 1);
        run_op(8'h00, 8'hFF, 1, 1'b0);
        run_op(8'hFF, 8'h00, MAXP, 1'b1);
        summary();
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule